// File: doc/BRIEF.md
# Horizontal Line Interrupt Scheduler

This block produces a periodic horizontal-line interrupt request for a pair of processors. Once a countdown is started, it waits a whole number of scanline periods and then emits a one-cycle pulse toward the interrupt controller. Each period is a fixed number of base-clock cycles (`LINE_CYCLES`), and the number of periods per interval is one more than a programmable line count. When a pulse fires, the next countdown is started at once under the same rules. This gives a steady stream of requests as long as the rules keep allowing one.

A countdown is started by a schedule request (`kickReq`, raised when software changes the relevant settings) or by the frame-start strobe. A countdown is only started if at least one processor has its horizontal-interrupt enable set. Past the last active scanline, scheduling is suppressed unless the blank-permit input is high. The scanline source and the interrupt controller are outside this block.

Top module: `hline_irq_sched`

## Requirements
- R1: A successful schedule loads a delay of (`lineCount`+1)×`LINE_CYCLES` cycles, and `hintPulse` goes high exactly that many clock cycles after the edge that accepted the request.
- R2: Scheduling is allowed only when bit 2 of at least one processor's 4-bit enable field is set. Processor i owns bits [4i+3:4i] of `enMasks`. With no such bit set, no pulse is ever produced.
- R3: If every processor's bit 2 is clear while a countdown is running, that countdown is cancelled. Setting a bit again afterwards does not revive it.
- R4: When `allowBlank` is low and `scanline` is greater than 224, no new countdown is started, whether from a request or from the reload after a pulse. When `allowBlank` is high, scanline 225 and above schedule normally. Line 224 itself schedules normally.
- R5: When a pulse fires and scheduling is still allowed, the next countdown is loaded on the same edge. Pulses therefore repeat every (`lineCount`+1)×`LINE_CYCLES` cycles.
- R6: `hintPulse` is high for exactly one clock cycle per expiry.
- R7: A change to `lineCount` during a countdown leaves that countdown unchanged and sets the length of the following one.
- R8: `frameStart` restarts the countdown from the full delay when `allowBlank` is low. When `allowBlank` is high, `frameStart` has no effect.
- R9: After reset, `hintPulse` is low and no countdown is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineCount | input | LC_W (8) | Lines per interval minus one |
| allowBlank | input | 1 | Permits scheduling past the last active line |
| enMasks | input | NUM_CPU*4 (8) | Per-processor interrupt enable fields, bit 2 = horizontal |
| scanline | input | SL_W (9) | Current scanline number |
| kickReq | input | 1 | Schedule request from a settings change |
| frameStart | input | 1 | Frame-start strobe |
| hintPulse | output | 1 | One-cycle horizontal interrupt trigger |

## Verification
The schedule function is exercised with several line counts, with each processor's enable alone and both together, and with masks where only bits other than bit 2 are set. These cases separate the delay arithmetic from the enable reduction. Scanlines 224, 225 and 240 are tried with the blank permit low and high, which pins down the exact comparison boundary and the override. Further sequences test how the block reacts to events during a countdown: a line-count change, a mask drop, a frame-start restart and a scanline move before expiry. Each distinguishes whether the running countdown or the next one is affected.

// File: rtl/hline_irq_pkg.sv
package hline_irq_pkg;
  // strobes from the control decision to the counting datapath
  typedef struct packed {
    logic load;   // load the freshly computed interval
    logic dec;    // count one cycle down
    logic clear;  // drop the running countdown
    logic fire;   // emit the trigger pulse
  } hintStrobe_t;

  localparam int unsigned HINT_BIT  = 2;
  localparam int unsigned MASK_W    = 4;
  localparam int unsigned LAST_LINE = 224;
endpackage

// File: rtl/hline_irq_ctrl.sv
module hline_irq_ctrl
  import hline_irq_pkg::*;
#(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned SL_W    = 9
) (
  input  logic                      allowBlank,
  input  logic [NUM_CPU*MASK_W-1:0] enMasks,
  input  logic [SL_W-1:0]           scanline,
  input  logic                      kickReq,
  input  logic                      frameStart,
  input  logic                      armed,
  input  logic                      atLast,
  output logic                      anyHint,
  output logic                      lineBlocked,
  output hintStrobe_t               strobe
);
  logic [NUM_CPU-1:0] hintBits;
  logic mayArm;
  logic startReq;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_pick
    assign hintBits[g] = enMasks[g*MASK_W + HINT_BIT];
  end

  assign anyHint     = |hintBits;
  assign lineBlocked = !allowBlank && (scanline > SL_W'(LAST_LINE));
  assign mayArm      = anyHint && !lineBlocked;
  assign startReq    = kickReq || (frameStart && !allowBlank);

  always_comb begin
    strobe = '0;
    if (!anyHint) begin
      strobe.clear = armed;
    end else if (armed && atLast) begin
      strobe.fire  = 1'b1;
      strobe.load  = mayArm;
      strobe.clear = !mayArm;
    end else if (startReq && mayArm) begin
      strobe.load = 1'b1;
    end else if (armed) begin
      strobe.dec = 1'b1;
    end
  end
endmodule

// File: rtl/hline_irq_dp.sv
module hline_irq_dp
  import hline_irq_pkg::*;
#(
  parameter int unsigned LC_W        = 8,
  parameter int unsigned LINE_CYCLES = 488,
  parameter int unsigned CNT_W       = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LC_W-1:0]   lineCount,
  input  hintStrobe_t       strobe,
  output logic              armed,
  output logic              atLast,
  output logic [CNT_W-1:0]  cnt,
  output logic              hintPulse
);
  logic [CNT_W-1:0] delay;

  assign delay  = (CNT_W'(lineCount) + CNT_W'(1)) * CNT_W'(LINE_CYCLES);
  assign atLast = armed && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt       <= '0;
      hintPulse <= 1'b0;
    end else begin
      hintPulse <= strobe.fire;
      if (strobe.clear) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (strobe.load) begin
        armed <= 1'b1;
        cnt   <= delay;
      end else if (strobe.dec) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hline_irq_sched.sv
module hline_irq_sched
  import hline_irq_pkg::*;
#(
  parameter int unsigned NUM_CPU     = 2,
  parameter int unsigned LC_W        = 8,
  parameter int unsigned SL_W        = 9,
  parameter int unsigned LINE_CYCLES = 488
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LC_W-1:0]           lineCount,
  input  logic                      allowBlank,
  input  logic [NUM_CPU*MASK_W-1:0] enMasks,
  input  logic [SL_W-1:0]           scanline,
  input  logic                      kickReq,
  input  logic                      frameStart,
  output logic                      hintPulse
);
  localparam int unsigned CNT_W = $clog2((2**LC_W) * LINE_CYCLES + 1);

  hintStrobe_t      strobe;
  logic             armed;
  logic             atLast;
  logic             anyHint;
  logic             lineBlocked;
  logic [CNT_W-1:0] cnt;

  hline_irq_ctrl #(.NUM_CPU(NUM_CPU), .SL_W(SL_W)) u_ctrl (
    .allowBlank (allowBlank),
    .enMasks    (enMasks),
    .scanline   (scanline),
    .kickReq    (kickReq),
    .frameStart (frameStart),
    .armed      (armed),
    .atLast     (atLast),
    .anyHint    (anyHint),
    .lineBlocked(lineBlocked),
    .strobe     (strobe)
  );

  hline_irq_dp #(.LC_W(LC_W), .LINE_CYCLES(LINE_CYCLES), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lineCount (lineCount),
    .strobe    (strobe),
    .armed     (armed),
    .atLast    (atLast),
    .cnt       (cnt),
    .hintPulse (hintPulse)
  );
endmodule

// File: rtl/hline_irq_sched_chk.sv
module hline_irq_sched_chk #(
  parameter int unsigned LC_W        = 8,
  parameter int unsigned LINE_CYCLES = 488,
  parameter int unsigned CNT_W       = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LC_W-1:0]  lineCount,
  input logic             hintPulse,
  input logic             anyHint,
  input logic             lineBlocked,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);
  // R1: a fresh countdown starts from the full interval
  p_load_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> cnt == (CNT_W'($past(lineCount)) + CNT_W'(1)) * CNT_W'(LINE_CYCLES));

  // R2: a pulse needs an enabled processor on the deciding edge
  p_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hintPulse |-> $past(anyHint));

  // R3: losing every enable drops the countdown
  p_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !anyHint |=> !armed);

  // R4: expiry past the active area without permit fires but does not reload
  p_block_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt == CNT_W'(1) && anyHint && lineBlocked) |=> (hintPulse && !armed));

  // R6: single-cycle trigger
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hintPulse |=> !hintPulse);
endmodule

bind hline_irq_sched hline_irq_sched_chk #(
  .LC_W(LC_W), .LINE_CYCLES(LINE_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lineCount  (lineCount),
  .hintPulse  (hintPulse),
  .anyHint    (anyHint),
  .lineBlocked(lineBlocked),
  .armed      (armed),
  .cnt        (cnt)
);

// File: tb/sim_hline_irq_sched.sv
module sim_hline_irq_sched;
  localparam int unsigned LC   = 488;
  localparam int unsigned NONE = 0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lineCount = '0;
  logic       allowBlank = 1'b0;
  logic [7:0] enMasks = '0;
  logic [8:0] scanline = '0;
  logic       kickReq = 1'b0;
  logic       frameStart = 1'b0;
  logic       hintPulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hline_irq_sched u0 (
    .clk(clk), .rst_n(rst_n), .lineCount(lineCount), .allowBlank(allowBlank),
    .enMasks(enMasks), .scanline(scanline), .kickReq(kickReq),
    .frameStart(frameStart), .hintPulse(hintPulse)
  );

  // vector: lineCount, cpu1 mask, cpu0 mask, allowBlank, scanline, expected delay (0 = none)
  typedef struct packed {
    logic [7:0]  lc;
    logic [3:0]  m1;
    logic [3:0]  m0;
    logic        ab;
    logic [8:0]  sl;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd0, 4'h0, 4'h4, 1'b0, 9'd10,  16'(1*LC)},   // R1 R2 cpu0 only
    '{8'd3, 4'h4, 4'h0, 1'b0, 9'd10,  16'(4*LC)},   // R1 R2 cpu1 only
    '{8'd1, 4'h4, 4'h4, 1'b0, 9'd100, 16'(2*LC)},   // R1 both
    '{8'd2, 4'h3, 4'hB, 1'b0, 9'd10,  16'(NONE)},   // R2 bit 2 clear everywhere
    '{8'd0, 4'h0, 4'h4, 1'b0, 9'd225, 16'(NONE)},   // R4 past active area
    '{8'd0, 4'h0, 4'h4, 1'b1, 9'd240, 16'(1*LC)},   // R4 permit set
    '{8'd0, 4'h4, 4'h0, 1'b0, 9'd224, 16'(1*LC)},   // R4 boundary line
    '{8'd2, 4'hF, 4'hF, 1'b0, 9'd0,   16'(3*LC)}    // R1 all bits set
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts falling edges until the pulse is seen, up to lim; returns 0 if none
  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (hintPulse) begin n = i; return; end
    end
  endtask

  task automatic kick();
    kickReq = 1'b1;
    @(negedge clk);
    kickReq = 1'b0;
  endtask

  task automatic frame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic quiesce();
    enMasks = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R9 pulse in reset", int'(hintPulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    enMasks = 8'h44;
    wait_pulse(1200, n);
    check("R9 idle after reset", n, 0);
    quiesce();

    foreach (VECS[k]) begin
      lineCount  = VECS[k].lc;
      enMasks    = {VECS[k].m1, VECS[k].m0};
      allowBlank = VECS[k].ab;
      scanline   = VECS[k].sl;
      kick();
      wait_pulse((VECS[k].exp == 0) ? 2500 : int'(VECS[k].exp) + 4, n);
      check($sformatf("R1/R2/R4 vector %0d", k), n, int'(VECS[k].exp));
      quiesce();
    end

    // R5 repeat and R6 width
    lineCount = 0; allowBlank = 0; scanline = 5; enMasks = 8'h04;
    kick();
    wait_pulse(600, n);
    check("R5 first interval", n, LC);
    @(negedge clk);
    check("R6 pulse width", int'(hintPulse), 0);
    wait_pulse(600, n);
    check("R5 repeat interval", n, LC - 1);
    quiesce();

    // R7 line count change mid-interval
    lineCount = 1; enMasks = 8'h40;
    kick();
    repeat (100) @(negedge clk);
    lineCount = 0;
    wait_pulse(1200, n);
    check("R7 running interval kept", n, 2*LC - 100);
    wait_pulse(1200, n);
    check("R7 next interval uses new count", n, LC);
    quiesce();

    // R8 frame start with permit low starts a countdown
    lineCount = 0; allowBlank = 0; scanline = 0; enMasks = 8'h04;
    frame();
    wait_pulse(600, n);
    check("R8 frame start schedules", n, LC);
    quiesce();

    // R8 frame start ignored with permit high
    allowBlank = 1; enMasks = 8'h04;
    frame();
    wait_pulse(1200, n);
    check("R8 frame start ignored", n, 0);
    quiesce();

    // R8 restart while running
    allowBlank = 0; enMasks = 8'h04;
    kick();
    repeat (200) @(negedge clk);
    frame();
    wait_pulse(600, n);
    check("R8 restart from full delay", n, LC);
    quiesce();

    // R3 cancel by dropping enables
    enMasks = 8'h44;
    kick();
    repeat (100) @(negedge clk);
    enMasks = 8'h00;
    @(negedge clk);
    enMasks = 8'h44;
    wait_pulse(1000, n);
    check("R3 cancelled countdown stays dead", n, 0);
    quiesce();

    // R4 reload blocked after moving past the active area
    enMasks = 8'h04; scanline = 10; allowBlank = 0;
    kick();
    repeat (100) @(negedge clk);
    scanline = 230;
    wait_pulse(600, n);
    check("R4 running countdown still fires", n, LC - 100);
    wait_pulse(1200, n);
    check("R4 no reload past active area", n, 0);
    quiesce();

    // R4 permit allows reload past active area
    allowBlank = 1; scanline = 230; enMasks = 8'h40;
    kick();
    wait_pulse(600, n);
    check("R4 permit first", n, LC);
    wait_pulse(600, n);
    check("R4 permit reload", n, LC);
    quiesce();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule